// File: doc/BRIEF.md
# Interrupt Context Save Controller

This block sits beside the program counter and register file of a small accumulator-based core and handles interrupt entry and return in hardware. When a request is taken, it copies the live accumulator, the carry and zero flags, the RAM page register and the six repeat-counter registers into shadow registers. In the same step it pushes the address after the current instruction onto a return stack. In the next cycle it asks the core to load the program counter with the fixed interrupt vector. Software never saves or reloads this context itself.

When the core decodes a return-from-interrupt instruction, it pulses the return strobe. In the cycle that follows, the block presents the shadow copy on its restore outputs together with a restore pulse. It also presents the stacked return address together with a PC-load pulse. Requests are masked from acceptance until the restore cycle has ended, so the shadow storage is only one level deep. A return strobe that arrives with no interrupt in service is flagged as an error and changes nothing.

Top module: `irq_ctx_ctrl`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `irq_ack`, `pc_load`, `ctx_restore`, `busy` and `iret_err` are all low.
- R2: When `irq_req` is high and the block is idle (`busy` low), `irq_ack` is high in that same cycle.
- R3: In the cycle after `irq_ack`, `pc_load` is high, `pc_load_addr` equals the vector address 0x000010 and `ctx_restore` is low.
- R4: In the restore cycle, `acc_out`, `c_out`, `z_out`, `page_out` and `rpt_out` equal the values of `acc_in`, `c_in`, `z_in`, `page_in` and `rpt_in` in the acknowledge cycle, whatever those inputs did in between. Repeat register k occupies bits [8k+7:8k] of the packed bus.
- R5: When `iret_stb` is high while an interrupt is in service, the next cycle is the restore cycle. In it, `ctx_restore` and `pc_load` are high for exactly one cycle, and `pc_load_addr` equals `pc_in` of the acknowledge cycle plus one.
- R6: `irq_ack` stays low from the cycle after an acknowledge through the restore cycle. A request held high through that span is acknowledged in the cycle right after the restore cycle.
- R7: A high `iret_stb` while idle, or during the restore cycle, gives a one-cycle `iret_err` pulse in the next cycle. It gives no `pc_load` and no `ctx_restore`, and it leaves `busy` and the restore outputs unchanged.
- R8: The return address wraps modulo 2^24: an interrupt taken at PC 0xFFFFFF returns to 0x000000.
- R9: `busy` is high from the cycle after an acknowledge through the restore cycle, and low in the cycle after it.
- R10: A `iret_stb` in the vector-load cycle is accepted as a valid return. The restore cycle follows it directly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_req | input | 1 | Interrupt request from the source arbiter |
| irq_ack | output | 1 | Request accepted this cycle |
| iret_stb | input | 1 | Return-from-interrupt decoded |
| pc_in | input | 24 | Address of the current instruction |
| acc_in | input | 8 | Live accumulator |
| c_in | input | 1 | Live carry flag |
| z_in | input | 1 | Live zero flag |
| page_in | input | 4 | Live RAM page register |
| rpt_in | input | 48 | Live repeat registers, register k in bits [8k+7:8k] |
| pc_load | output | 1 | Core loads `pc_load_addr` into the PC |
| pc_load_addr | output | 24 | Vector or return address |
| ctx_restore | output | 1 | Core loads the restore outputs into its registers |
| acc_out | output | 8 | Saved accumulator |
| c_out | output | 1 | Saved carry flag |
| z_out | output | 1 | Saved zero flag |
| page_out | output | 4 | Saved RAM page |
| rpt_out | output | 48 | Saved repeat registers |
| busy | output | 1 | Interrupt entered and not yet returned |
| iret_err | output | 1 | Return strobe seen with no interrupt in service |

## Verification
The live inputs change to fresh values right after each acknowledge. A restore that matches the acknowledge-cycle values therefore shows that the shadow copy was taken at the right edge and not later. A request held high across a whole service period separates correct masking from early re-entry: only one acknowledge may show, and it must come in the cycle after the restore. Return strobes are sent while idle, in the vector-load cycle and in the restore cycle. These tell the error path apart from a genuine return. An entry at PC 0xFFFFFF exercises the wrap of the return address.

// File: rtl/irq_ctx_pkg.sv
package irq_ctx_pkg;

  // Service sequence: vector load follows acceptance, restore follows return.
  typedef enum logic [1:0] {
    SEQ_IDLE   = 2'd0,
    SEQ_ENTER  = 2'd1,
    SEQ_SERVE  = 2'd2,
    SEQ_RETURN = 2'd3
  } seq_state_e;

endpackage

// File: rtl/irq_ctx_seq.sv
module irq_ctx_seq
  import irq_ctx_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic irq_req,
  input  logic iret_stb,
  output logic irq_ack,
  output logic enter_cyc,
  output logic return_cyc,
  output logic busy,
  output logic iret_err
);

  seq_state_e st_q, st_d;
  logic       err_q, err_d;

  always_comb begin
    st_d    = st_q;
    irq_ack = irq_req && (st_q == SEQ_IDLE);
    err_d   = iret_stb && ((st_q == SEQ_IDLE) || (st_q == SEQ_RETURN));
    case (st_q)
      SEQ_IDLE:   if (irq_req) st_d = SEQ_ENTER;
      SEQ_ENTER:  st_d = iret_stb ? SEQ_RETURN : SEQ_SERVE;
      SEQ_SERVE:  if (iret_stb) st_d = SEQ_RETURN;
      SEQ_RETURN: st_d = SEQ_IDLE;
      default:    st_d = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= SEQ_IDLE;
      err_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      err_q <= err_d;
    end
  end

  assign enter_cyc  = (st_q == SEQ_ENTER);
  assign return_cyc = (st_q == SEQ_RETURN);
  assign busy       = (st_q != SEQ_IDLE);
  assign iret_err   = err_q;

endmodule

// File: rtl/irq_ret_stack.sv
module irq_ret_stack #(
  parameter int unsigned ADDR_W = 24,
  parameter int unsigned DEPTH  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic              pop,
  input  logic [ADDR_W-1:0] push_addr,
  output logic [ADDR_W-1:0] top_addr
);

  localparam int unsigned CNT_W = $clog2(DEPTH + 1);

  logic [ADDR_W-1:0] slot_q [DEPTH];
  logic [ADDR_W-1:0] slot_d [DEPTH];
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              do_push, do_pop;

  assign do_push = push && (cnt_q != CNT_W'(DEPTH));
  assign do_pop  = pop && (cnt_q != '0);

  always_comb begin
    cnt_d = cnt_q;
    if (do_push)     cnt_d = cnt_q + CNT_W'(1);
    else if (do_pop) cnt_d = cnt_q - CNT_W'(1);
    for (int i = 0; i < int'(DEPTH); i++) begin
      slot_d[i] = slot_q[i];
      if (do_push && (cnt_q == CNT_W'(i))) slot_d[i] = push_addr;
    end
  end

  always_comb begin
    top_addr = '0;
    for (int i = 0; i < int'(DEPTH); i++) begin
      if (cnt_q == CNT_W'(i + 1)) top_addr = slot_q[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      for (int i = 0; i < int'(DEPTH); i++) slot_q[i] <= '0;
    end else begin
      cnt_q <= cnt_d;
      for (int i = 0; i < int'(DEPTH); i++) slot_q[i] <= slot_d[i];
    end
  end

endmodule

// File: rtl/irq_ctx_shadow.sv
module irq_ctx_shadow #(
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned PAGE_W  = 4,
  parameter int unsigned NUM_RPT = 6
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cap,
  input  logic [DATA_W-1:0]         acc_in,
  input  logic                      c_in,
  input  logic                      z_in,
  input  logic [PAGE_W-1:0]         page_in,
  input  logic [NUM_RPT*DATA_W-1:0] rpt_in,
  output logic [DATA_W-1:0]         acc_q,
  output logic                      c_q,
  output logic                      z_q,
  output logic [PAGE_W-1:0]         page_q,
  output logic [NUM_RPT*DATA_W-1:0] rpt_q
);

  logic [DATA_W-1:0] acc_d;
  logic              c_d, z_d;
  logic [PAGE_W-1:0] page_d;

  always_comb begin
    acc_d  = cap ? acc_in  : acc_q;
    c_d    = cap ? c_in    : c_q;
    z_d    = cap ? z_in    : z_q;
    page_d = cap ? page_in : page_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= '0;
      c_q    <= 1'b0;
      z_q    <= 1'b0;
      page_q <= '0;
    end else begin
      acc_q  <= acc_d;
      c_q    <= c_d;
      z_q    <= z_d;
      page_q <= page_d;
    end
  end

  for (genvar k = 0; k < int'(NUM_RPT); k++) begin : g_rpt
    logic [DATA_W-1:0] r_d;
    assign r_d = cap ? rpt_in[k*DATA_W +: DATA_W] : rpt_q[k*DATA_W +: DATA_W];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rpt_q[k*DATA_W +: DATA_W] <= '0;
      else        rpt_q[k*DATA_W +: DATA_W] <= r_d;
    end
  end

endmodule

// File: rtl/irq_ctx_ctrl.sv
module irq_ctx_ctrl #(
  parameter int unsigned PC_W      = 24,
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned PAGE_W    = 4,
  parameter int unsigned NUM_RPT   = 6,
  parameter int unsigned STK_DEPTH = 2,
  parameter int unsigned VEC_ADDR  = 32'h0000_0010
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      irq_req,
  output logic                      irq_ack,
  input  logic                      iret_stb,
  input  logic [PC_W-1:0]           pc_in,
  input  logic [DATA_W-1:0]         acc_in,
  input  logic                      c_in,
  input  logic                      z_in,
  input  logic [PAGE_W-1:0]         page_in,
  input  logic [NUM_RPT*DATA_W-1:0] rpt_in,
  output logic                      pc_load,
  output logic [PC_W-1:0]           pc_load_addr,
  output logic                      ctx_restore,
  output logic [DATA_W-1:0]         acc_out,
  output logic                      c_out,
  output logic                      z_out,
  output logic [PAGE_W-1:0]         page_out,
  output logic [NUM_RPT*DATA_W-1:0] rpt_out,
  output logic                      busy,
  output logic                      iret_err
);

  localparam logic [PC_W-1:0] VEC_PC = PC_W'(VEC_ADDR);

  logic            enter_cyc, return_cyc;
  logic [PC_W-1:0] ret_top, ret_next;

  assign ret_next = pc_in + PC_W'(1);

  irq_ctx_seq u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .irq_req    (irq_req),
    .iret_stb   (iret_stb),
    .irq_ack    (irq_ack),
    .enter_cyc  (enter_cyc),
    .return_cyc (return_cyc),
    .busy       (busy),
    .iret_err   (iret_err)
  );

  irq_ret_stack #(
    .ADDR_W (PC_W),
    .DEPTH  (STK_DEPTH)
  ) u_stack (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (irq_ack),
    .pop       (return_cyc),
    .push_addr (ret_next),
    .top_addr  (ret_top)
  );

  irq_ctx_shadow #(
    .DATA_W  (DATA_W),
    .PAGE_W  (PAGE_W),
    .NUM_RPT (NUM_RPT)
  ) u_shadow (
    .clk     (clk),
    .rst_n   (rst_n),
    .cap     (irq_ack),
    .acc_in  (acc_in),
    .c_in    (c_in),
    .z_in    (z_in),
    .page_in (page_in),
    .rpt_in  (rpt_in),
    .acc_q   (acc_out),
    .c_q     (c_out),
    .z_q     (z_out),
    .page_q  (page_out),
    .rpt_q   (rpt_out)
  );

  always_comb begin
    pc_load      = enter_cyc || return_cyc;
    pc_load_addr = return_cyc ? ret_top : VEC_PC;
    ctx_restore  = return_cyc;
  end

endmodule

// File: rtl/irq_ctx_chk.sv
module irq_ctx_chk #(
  parameter int unsigned PC_W     = 24,
  parameter int unsigned VEC_ADDR = 32'h0000_0010
) (
  input logic            clk,
  input logic            rst_n,
  input logic            irq_ack,
  input logic            iret_stb,
  input logic            pc_load,
  input logic [PC_W-1:0] pc_load_addr,
  input logic            ctx_restore,
  input logic            busy,
  input logic            iret_err
);

  AST_VECTOR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ack |=> (pc_load && !ctx_restore && (pc_load_addr == PC_W'(VEC_ADDR)))); // R3

  AST_RESTORE_WITH_PC: assert property (@(posedge clk) disable iff (!rst_n)
    ctx_restore |-> pc_load); // R5

  AST_RESTORE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    ctx_restore |=> !ctx_restore); // R5

  AST_MASKED_IN_SERVICE: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !irq_ack); // R6

  AST_BUSY_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ack |=> busy); // R9

  AST_BAD_RETURN: assert property (@(posedge clk) disable iff (!rst_n)
    (iret_stb && !busy && !irq_ack) |=> (iret_err && !ctx_restore && !pc_load)); // R7

  AST_ERR_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    iret_err |-> $past(iret_stb)); // R7

endmodule

bind irq_ctx_ctrl irq_ctx_chk #(
  .PC_W     (PC_W),
  .VEC_ADDR (VEC_ADDR)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .irq_ack      (irq_ack),
  .iret_stb     (iret_stb),
  .pc_load      (pc_load),
  .pc_load_addr (pc_load_addr),
  .ctx_restore  (ctx_restore),
  .busy         (busy),
  .iret_err     (iret_err)
);

// File: tb/test_irq_ctx_ctrl.sv
module test_irq_ctx_ctrl;

  localparam int CLK_P = 10;

  typedef struct packed {
    logic [23:0] addr;
    logic        restore;
    logic [7:0]  acc;
    logic        c;
    logic        z;
    logic [3:0]  page;
    logic [47:0] rpt;
  } exp_t;

  logic        clk, rst_n, irq_req, iret_stb;
  logic        irq_ack, pc_load, ctx_restore, busy, iret_err;
  logic [23:0] pc_in, pc_load_addr;
  logic [7:0]  acc_in, acc_out;
  logic        c_in, z_in, c_out, z_out;
  logic [3:0]  page_in, page_out;
  logic [47:0] rpt_in, rpt_out;

  int          n_chk, n_fail, n_restore;
  logic [23:0] last_ret;
  exp_t        sbq[$];
  exp_t        sv;

  irq_ctx_ctrl i_irq_ctx_ctrl (
    .clk (clk), .rst_n (rst_n), .irq_req (irq_req), .irq_ack (irq_ack),
    .iret_stb (iret_stb), .pc_in (pc_in), .acc_in (acc_in), .c_in (c_in),
    .z_in (z_in), .page_in (page_in), .rpt_in (rpt_in), .pc_load (pc_load),
    .pc_load_addr (pc_load_addr), .ctx_restore (ctx_restore),
    .acc_out (acc_out), .c_out (c_out), .z_out (z_out),
    .page_out (page_out), .rpt_out (rpt_out), .busy (busy),
    .iret_err (iret_err)
  );

  initial clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  task automatic chk(input bit ok, input string req,
                     input logic [63:0] act, input logic [63:0] expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic set_live(input logic [23:0] pc, input logic [7:0] a,
                          input logic c, input logic z,
                          input logic [3:0] pg, input logic [47:0] r);
    pc_in = pc; acc_in = a; c_in = c; z_in = z; page_in = pg; rpt_in = r;
  endtask

  // Expect an acknowledge in this cycle, record the context, queue the vector load.
  task automatic accept();
    exp_t e;
    @(negedge clk);
    chk(irq_ack === 1'b1, "R2", 64'(irq_ack), 64'd1);
    sv = '{addr: pc_in + 24'd1, restore: 1'b1, acc: acc_in, c: c_in,
           z: z_in, page: page_in, rpt: rpt_in};
    e = '0;
    e.addr = 24'h000010;
    sbq.push_back(e);
    step();
  endtask

  // Scoreboard monitor: every PC load must match the oldest queued item.
  always @(negedge clk) begin : mon_p
    exp_t e;
    if (rst_n) begin
      if (pc_load) begin
        if (sbq.size() == 0) begin
          chk(1'b0, "R7", 64'(pc_load_addr), 64'd0);
        end else begin
          e = sbq.pop_front();
          chk(pc_load_addr == e.addr, e.restore ? "R5" : "R3",
              64'(pc_load_addr), 64'(e.addr));
          chk(ctx_restore == e.restore, "R5", 64'(ctx_restore), 64'(e.restore));
          if (e.restore) begin
            n_restore++;
            last_ret = pc_load_addr;
            chk({acc_out, c_out, z_out, page_out, rpt_out} ==
                {e.acc, e.c, e.z, e.page, e.rpt}, "R4",
                64'({acc_out, c_out, z_out, page_out, rpt_out}),
                64'({e.acc, e.c, e.z, e.page, e.rpt}));
          end
        end
      end else if (ctx_restore) begin
        chk(1'b0, "R5", 64'd1, 64'd0);
      end
    end
  end

  initial begin
    #(CLK_P * 20000);
    chk(1'b0, "watchdog", 64'd0, 64'd1);
    summary();
  end

  initial begin
    n_chk = 0; n_fail = 0; n_restore = 0; last_ret = '1;
    rst_n = 1'b0; irq_req = 1'b0; iret_stb = 1'b0;
    set_live(24'h0, 8'h0, 1'b0, 1'b0, 4'h0, 48'h0);
    repeat (3) step();
    @(negedge clk);
    chk({irq_ack, pc_load, ctx_restore, busy, iret_err} == 5'b0, "R1",
        64'({irq_ack, pc_load, ctx_restore, busy, iret_err}), 64'd0);
    step();
    rst_n = 1'b1;
    @(negedge clk);
    chk({irq_ack, pc_load, ctx_restore, busy, iret_err} == 5'b0, "R1",
        64'({irq_ack, pc_load, ctx_restore, busy, iret_err}), 64'd0);
    step();

    // First entry; the request stays high through the whole service.
    set_live(24'h001234, 8'hA5, 1'b1, 1'b0, 4'h3, 48'h665544332211);
    irq_req = 1'b1;
    accept();
    set_live(24'h00ABCD, 8'h5A, 1'b0, 1'b1, 4'hC, 48'hFFEEDDCCBBAA);
    @(negedge clk);
    chk(busy === 1'b1, "R9", 64'(busy), 64'd1);
    chk(irq_ack === 1'b0, "R6", 64'(irq_ack), 64'd0);
    step();
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(irq_ack === 1'b0, "R6", 64'(irq_ack), 64'd0);
      chk(busy === 1'b1, "R9", 64'(busy), 64'd1);
      step();
    end
    sbq.push_back(sv);
    iret_stb = 1'b1;
    @(negedge clk);
    chk(irq_ack === 1'b0, "R6", 64'(irq_ack), 64'd0);
    step();
    iret_stb = 1'b0;
    @(negedge clk);
    chk(irq_ack === 1'b0, "R6", 64'(irq_ack), 64'd0);
    chk(busy === 1'b1, "R9", 64'(busy), 64'd1);
    step();
    // Held request is taken right after the restore cycle.
    accept();
    irq_req = 1'b0;
    set_live(24'h777777, 8'h11, 1'b1, 1'b1, 4'h9, 48'h010203040506);
    step();
    sbq.push_back(sv);
    iret_stb = 1'b1;
    step();
    iret_stb = 1'b0;
    step();
    @(negedge clk);
    chk(busy === 1'b0, "R9", 64'(busy), 64'd0);
    chk(last_ret == 24'h00ABCE, "R5", 64'(last_ret), 64'h00ABCE);
    step();

    // Return strobe while idle.
    iret_stb = 1'b1;
    step();
    iret_stb = 1'b0;
    @(negedge clk);
    chk(iret_err === 1'b1, "R7", 64'(iret_err), 64'd1);
    chk(busy === 1'b0, "R7", 64'(busy), 64'd0);
    chk(acc_out == 8'h5A && rpt_out == 48'hFFEEDDCCBBAA, "R7",
        64'({acc_out, rpt_out[7:0]}), 64'h5AAA);
    step();
    @(negedge clk);
    chk(iret_err === 1'b0, "R7", 64'(iret_err), 64'd0);
    step();

    // Entry at the top of the address space; return in the vector-load
    // cycle, strobe held into the restore cycle.
    set_live(24'hFFFFFF, 8'h3C, 1'b0, 1'b1, 4'hF, 48'h0F0E0D0C0B0A);
    irq_req = 1'b1;
    accept();
    irq_req = 1'b0;
    set_live(24'h000100, 8'h00, 1'b1, 1'b0, 4'h0, 48'h0);
    sbq.push_back(sv);
    iret_stb = 1'b1;
    step();
    @(negedge clk);
    chk(ctx_restore === 1'b1, "R10", 64'(ctx_restore), 64'd1);
    step();
    iret_stb = 1'b0;
    @(negedge clk);
    chk(iret_err === 1'b1, "R7", 64'(iret_err), 64'd1);
    chk(busy === 1'b0, "R7", 64'(busy), 64'd0);
    chk(last_ret == 24'h000000, "R8", 64'(last_ret), 64'd0);
    step();
    repeat (2) step();
    chk(sbq.size() == 0, "R10", 64'(sbq.size()), 64'd0);
    chk(n_restore == 3, "R5", 64'(n_restore), 64'd3);
    summary();
  end

endmodule